// File: doc/BRIEF.md
# Multicore Interrupt Distributor

This block sits between a set of external interrupt sources and the cores of a small multiprocessor cluster. Each external line can be steered to one or more cores through a routing entry, and passes only while its bit in a global enable mask is set. That mask is never written whole. One address sets the bits given as ones, and another address clears them. Software can also force an external line active through a global assert register.

Cores signal each other through inter-processor interrupts. A write to a post address raises one cause bit on every core named in the write data. Each core has its own set of pending causes. These are OR-ed into a single interrupt output for that core and acknowledged by writing ones to that core's cause register.

The register file also holds the following:
- a read-only configuration word giving the release, the core count and an identifier;
- an 8-bit partition register;
- one stall bit per core, which drives that core's stall output;
- a coherency-enable bit that is only stored.

All access goes through a single-cycle external register bus. Writes take effect at the clock edge. Read data is combinational from the address while the read strobe is high.

Top module: `mcid_top`

## Requirements
- R1: Routing entry n is at address 0x000+n. Its low NUM_CORES bits are a core mask that reads back as written. Output bit p*NUM_EXT+n of `core_ext_irq` is high exactly when (irq_in[n] OR assert bit n) is high, enable bit n is set, and bit p of routing entry n is set.
- R2: A write to 0x180 clears each enable bit whose write-data bit is one and leaves the other enable bits unchanged. Reads of 0x180 and 0x184 return the enable mask.
- R3: A write to 0x184 sets each enable bit whose write-data bit is one and leaves the other enable bits unchanged.
- R4: A write to 0x140+c, with c below NUM_CAUSES, sets pending cause c on every core p whose write-data bit p is one.
- R5: `ipi_irq[p]` is the OR of core p's pending causes. A read of 0x100+p returns those causes in its low NUM_CAUSES bits.
- R6: A write to 0x100+p clears the pending causes of core p whose write-data bits are one. The other causes are unchanged.
- R7: A write to 0x18C sets bits of the global assert register, and a write to 0x188 clears the bits written as one. Reads of both addresses return the register. A set bit n acts as an active input line n in R1.
- R8: Address 0x190 holds an 8-bit partition value. It reads back in bits [7:0], and bits [31:8] read zero.
- R9: A read of 0x1A0 returns {release[9:0], NUM_CORES-1 in 4 bits, id[17:0]}, with the release in bits [31:22] and the id in bits [17:0]. Writes to 0x1A0 have no effect.
- R10: Address 0x200 holds one stall bit per core in its low bits. Bit p drives `core_stall[p]` and reads back.
- R11: Address 0x220 bit 0 is a coherency-enable flag that is stored and read back only.
- R12: After reset the following hold:
  - all enable bits, assert bits, pending causes, stall bits, partition and coherency bits are zero;
  - every routing entry is 1, which selects core 0;
  - all outputs are low.
  Reads of unmapped addresses return zero, and `bus_rdata` is zero while `bus_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | NUM_EXT | External interrupt lines, active high |
| bus_addr | input | 10 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, zero when no read |
| core_ext_irq | output | NUM_CORES*NUM_EXT | Gated external interrupts, bit p*NUM_EXT+n is line n at core p |
| ipi_irq | output | NUM_CORES | One OR-ed inter-processor interrupt per core |
| core_stall | output | NUM_CORES | Per-core stall |

## Verification
A wrong routing entry or enable bit sends a line to the wrong core or blocks it. This appears on `core_ext_irq` in the cycle after the write, as soon as the line is driven. The bench therefore walks every line through every core, under several input patterns.

A lost or misplaced cause bit shows on `ipi_irq` one cycle after the post or acknowledge, and also in the per-core cause readback. Each post uses a different core mask, so a mixed-up core index or cause index gives a wrong cause pattern at once. Faults in the stall, partition and coherency registers appear directly in their read values.

// File: rtl/mcid_pkg.sv
package mcid_pkg;

    localparam int ADDR_W = 10;
    localparam int DATA_W = 32;

    localparam logic [ADDR_W-1:0] ROUTE_BASE = 10'h000;
    localparam logic [ADDR_W-1:0] CAUSE_BASE = 10'h100;
    localparam logic [ADDR_W-1:0] POST_BASE  = 10'h140;
    localparam logic [ADDR_W-1:0] EN_CLR_AD  = 10'h180;
    localparam logic [ADDR_W-1:0] EN_SET_AD  = 10'h184;
    localparam logic [ADDR_W-1:0] ASG_CLR_AD = 10'h188;
    localparam logic [ADDR_W-1:0] ASG_SET_AD = 10'h18C;
    localparam logic [ADDR_W-1:0] PART_AD    = 10'h190;
    localparam logic [ADDR_W-1:0] CFG_AD     = 10'h1A0;
    localparam logic [ADDR_W-1:0] STALL_AD   = 10'h200;
    localparam logic [ADDR_W-1:0] COH_AD     = 10'h220;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_ROUTE,
        SEL_CAUSE,
        SEL_POST,
        SEL_EN_CLR,
        SEL_EN_SET,
        SEL_ASG_CLR,
        SEL_ASG_SET,
        SEL_PART,
        SEL_CFG,
        SEL_STALL,
        SEL_COH
    } reg_sel_e;

    typedef struct packed {
        reg_sel_e   sel;
        logic [7:0] idx;
    } dec_t;

    function automatic logic in_window(input logic [ADDR_W-1:0] a,
                                       input logic [ADDR_W-1:0] base,
                                       input int count);
        return (int'(a) >= int'(base)) && (int'(a) < int'(base) + count);
    endfunction

    function automatic logic [DATA_W-1:0] cfg_word(input logic [9:0]  rel,
                                                   input logic [3:0]  cores_m1,
                                                   input logic [17:0] id);
        return {rel, cores_m1, id};
    endfunction

endpackage

// File: rtl/mcid_decode.sv
module mcid_decode import mcid_pkg::*; #(
    parameter int NUM_EXT    = 8,
    parameter int NUM_CORES  = 4,
    parameter int NUM_CAUSES = 4
) (
    input  logic [ADDR_W-1:0] addr,
    output dec_t              dec
);

    always_comb begin
        dec.sel = SEL_NONE;
        dec.idx = '0;
        if (in_window(addr, ROUTE_BASE, NUM_EXT)) begin
            dec.sel = SEL_ROUTE;
            dec.idx = 8'(addr - ROUTE_BASE);
        end else if (in_window(addr, CAUSE_BASE, NUM_CORES)) begin
            dec.sel = SEL_CAUSE;
            dec.idx = 8'(addr - CAUSE_BASE);
        end else if (in_window(addr, POST_BASE, NUM_CAUSES)) begin
            dec.sel = SEL_POST;
            dec.idx = 8'(addr - POST_BASE);
        end else begin
            case (addr)
                EN_CLR_AD:  dec.sel = SEL_EN_CLR;
                EN_SET_AD:  dec.sel = SEL_EN_SET;
                ASG_CLR_AD: dec.sel = SEL_ASG_CLR;
                ASG_SET_AD: dec.sel = SEL_ASG_SET;
                PART_AD:    dec.sel = SEL_PART;
                CFG_AD:     dec.sel = SEL_CFG;
                STALL_AD:   dec.sel = SEL_STALL;
                COH_AD:     dec.sel = SEL_COH;
                default:    dec.sel = SEL_NONE;
            endcase
        end
    end

endmodule

// File: rtl/mcid_route.sv
module mcid_route import mcid_pkg::*; #(
    parameter int NUM_EXT   = 8,
    parameter int NUM_CORES = 4
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          wr,
    input  dec_t                          dec,
    input  logic [NUM_EXT-1:0]            wmask,
    input  logic [NUM_CORES-1:0]          wcore,
    input  logic [NUM_EXT-1:0]            irq_in,
    output logic [NUM_CORES-1:0]          route_rd,
    output logic [NUM_EXT-1:0]            en_q,
    output logic [NUM_EXT-1:0]            asg_q,
    output logic [NUM_CORES*NUM_EXT-1:0]  core_ext_irq
);

    localparam logic [NUM_CORES-1:0] ROUTE_RST = NUM_CORES'(1);

    logic [NUM_CORES-1:0] route_q [NUM_EXT];
    logic [NUM_EXT-1:0]   line;

    // one routing entry per external line
    for (genvar n = 0; n < NUM_EXT; n++) begin : g_route
        always_ff @(posedge clk) begin
            if (rst)
                route_q[n] <= ROUTE_RST;
            else if (wr && dec.sel == SEL_ROUTE && dec.idx == 8'(n))
                route_q[n] <= wcore;
        end
    end

    always_comb begin
        route_rd = '0;
        for (int n = 0; n < NUM_EXT; n++)
            if (dec.idx == 8'(n))
                route_rd = route_q[n];
    end

    // enable and assert masks: only set-by-one and clear-by-one updates
    always_ff @(posedge clk) begin
        if (rst) begin
            en_q  <= '0;
            asg_q <= '0;
        end else if (wr) begin
            case (dec.sel)
                SEL_EN_SET:  en_q  <= en_q | wmask;
                SEL_EN_CLR:  en_q  <= en_q & ~wmask;
                SEL_ASG_SET: asg_q <= asg_q | wmask;
                SEL_ASG_CLR: asg_q <= asg_q & ~wmask;
                default: ;
            endcase
        end
    end

    assign line = irq_in | asg_q;

    for (genvar p = 0; p < NUM_CORES; p++) begin : g_core
        for (genvar n = 0; n < NUM_EXT; n++) begin : g_line
            assign core_ext_irq[p*NUM_EXT+n] = line[n] & en_q[n] & route_q[n][p];
        end
    end

endmodule

// File: rtl/mcid_ipi.sv
module mcid_ipi #(
    parameter int NUM_CORES  = 4,
    parameter int NUM_CAUSES = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  post_we,
    input  logic                  ack_we,
    input  logic [7:0]            idx,
    input  logic [NUM_CORES-1:0]  wcore,
    input  logic [NUM_CAUSES-1:0] wcause,
    output logic [NUM_CAUSES-1:0] cause_rd,
    output logic [NUM_CORES-1:0]  ipi_irq
);

    logic [NUM_CAUSES-1:0] pend_q [NUM_CORES];

    for (genvar p = 0; p < NUM_CORES; p++) begin : g_core
        always_ff @(posedge clk) begin
            if (rst) begin
                pend_q[p] <= '0;
            end else begin
                for (int c = 0; c < NUM_CAUSES; c++) begin
                    if (post_we && wcore[p] && idx == 8'(c))
                        pend_q[p][c] <= 1'b1;
                    else if (ack_we && idx == 8'(p) && wcause[c])
                        pend_q[p][c] <= 1'b0;
                end
            end
        end
        assign ipi_irq[p] = |pend_q[p];
    end

    always_comb begin
        cause_rd = '0;
        for (int p = 0; p < NUM_CORES; p++)
            if (idx == 8'(p))
                cause_rd = pend_q[p];
    end

endmodule

// File: rtl/mcid_misc.sv
module mcid_misc #(
    parameter int NUM_CORES = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 part_we,
    input  logic                 stall_we,
    input  logic                 coh_we,
    input  logic [7:0]           wpart,
    input  logic [NUM_CORES-1:0] wstall,
    input  logic                 wcoh,
    output logic [7:0]           part_q,
    output logic [NUM_CORES-1:0] stall_q,
    output logic                 coh_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            part_q  <= '0;
            stall_q <= '0;
            coh_q   <= 1'b0;
        end else begin
            if (part_we)  part_q  <= wpart;
            if (stall_we) stall_q <= wstall;
            if (coh_we)   coh_q   <= wcoh;
        end
    end

endmodule

// File: rtl/mcid_top.sv
module mcid_top import mcid_pkg::*; #(
    parameter int          NUM_CORES  = 4,
    parameter int          NUM_EXT    = 8,
    parameter int          NUM_CAUSES = 4,
    parameter logic [9:0]  REL_VER    = 10'h2A5,
    parameter logic [17:0] CHIP_ID    = 18'h1C0DE
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [NUM_EXT-1:0]           irq_in,
    input  logic [ADDR_W-1:0]            bus_addr,
    input  logic                         bus_wr,
    input  logic                         bus_rd,
    input  logic [DATA_W-1:0]            bus_wdata,
    output logic [DATA_W-1:0]            bus_rdata,
    output logic [NUM_CORES*NUM_EXT-1:0] core_ext_irq,
    output logic [NUM_CORES-1:0]         ipi_irq,
    output logic [NUM_CORES-1:0]         core_stall
);

    localparam logic [DATA_W-1:0] CFG_WORD = cfg_word(REL_VER, 4'(NUM_CORES-1), CHIP_ID);

    dec_t                  dec;
    logic [NUM_CORES-1:0]  route_rd;
    logic [NUM_EXT-1:0]    en_q;
    logic [NUM_EXT-1:0]    asg_q;
    logic [NUM_CAUSES-1:0] cause_rd;
    logic [7:0]            part_q;
    logic                  coh_q;
    logic [DATA_W-1:0]     rd_mux;
    logic                  unused_wdata;

    assign unused_wdata = ^bus_wdata;

    mcid_decode #(
        .NUM_EXT(NUM_EXT), .NUM_CORES(NUM_CORES), .NUM_CAUSES(NUM_CAUSES)
    ) u_decode (
        .addr (bus_addr),
        .dec  (dec)
    );

    mcid_route #(
        .NUM_EXT(NUM_EXT), .NUM_CORES(NUM_CORES)
    ) u_route (
        .clk          (clk),
        .rst          (rst),
        .wr           (bus_wr),
        .dec          (dec),
        .wmask        (bus_wdata[NUM_EXT-1:0]),
        .wcore        (bus_wdata[NUM_CORES-1:0]),
        .irq_in       (irq_in),
        .route_rd     (route_rd),
        .en_q         (en_q),
        .asg_q        (asg_q),
        .core_ext_irq (core_ext_irq)
    );

    mcid_ipi #(
        .NUM_CORES(NUM_CORES), .NUM_CAUSES(NUM_CAUSES)
    ) u_ipi (
        .clk      (clk),
        .rst      (rst),
        .post_we  (bus_wr && dec.sel == SEL_POST),
        .ack_we   (bus_wr && dec.sel == SEL_CAUSE),
        .idx      (dec.idx),
        .wcore    (bus_wdata[NUM_CORES-1:0]),
        .wcause   (bus_wdata[NUM_CAUSES-1:0]),
        .cause_rd (cause_rd),
        .ipi_irq  (ipi_irq)
    );

    mcid_misc #(
        .NUM_CORES(NUM_CORES)
    ) u_misc (
        .clk      (clk),
        .rst      (rst),
        .part_we  (bus_wr && dec.sel == SEL_PART),
        .stall_we (bus_wr && dec.sel == SEL_STALL),
        .coh_we   (bus_wr && dec.sel == SEL_COH),
        .wpart    (bus_wdata[7:0]),
        .wstall   (bus_wdata[NUM_CORES-1:0]),
        .wcoh     (bus_wdata[0]),
        .part_q   (part_q),
        .stall_q  (core_stall),
        .coh_q    (coh_q)
    );

    always_comb begin
        case (dec.sel)
            SEL_ROUTE:               rd_mux = DATA_W'(route_rd);
            SEL_CAUSE:               rd_mux = DATA_W'(cause_rd);
            SEL_EN_CLR, SEL_EN_SET:  rd_mux = DATA_W'(en_q);
            SEL_ASG_CLR, SEL_ASG_SET: rd_mux = DATA_W'(asg_q);
            SEL_PART:                rd_mux = DATA_W'(part_q);
            SEL_CFG:                 rd_mux = CFG_WORD;
            SEL_STALL:               rd_mux = DATA_W'(core_stall);
            SEL_COH:                 rd_mux = DATA_W'(coh_q);
            default:                 rd_mux = '0;
        endcase
    end

    assign bus_rdata = bus_rd ? rd_mux : '0;

endmodule

// File: rtl/mcid_checker.sv
module mcid_checker import mcid_pkg::*; #(
    parameter int NUM_CORES  = 4,
    parameter int NUM_EXT    = 8,
    parameter int NUM_CAUSES = 4
) (
    input logic                         clk,
    input logic                         rst,
    input logic [ADDR_W-1:0]            bus_addr,
    input logic                         bus_wr,
    input logic                         bus_rd,
    input logic [DATA_W-1:0]            bus_wdata,
    input logic [DATA_W-1:0]            bus_rdata,
    input logic [NUM_CORES*NUM_EXT-1:0] core_ext_irq,
    input logic [NUM_CORES-1:0]         ipi_irq,
    input logic [NUM_CORES-1:0]         core_stall
);

    // clearing enable bit 0 silences line 0 at core 0 (R2)
    assert_en_clear_R2: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == EN_CLR_AD && bus_wdata[0]) |=> !core_ext_irq[0]);

    assert_post_raises_R4: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == POST_BASE && bus_wdata[0]) |=> ipi_irq[0]);

    assert_ack_drops_R6: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == CAUSE_BASE && (&bus_wdata[NUM_CAUSES-1:0])) |=> !ipi_irq[0]);

    assert_cfg_cores_R9: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == CFG_AD) |-> (bus_rdata[21:18] == 4'(NUM_CORES-1)));

    assert_stall_follows_R10: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == STALL_AD) |=> (core_stall == $past(bus_wdata[NUM_CORES-1:0])));

    assert_quiet_bus_R12: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |-> (bus_rdata == '0));

    assert_reset_clear_R12: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (ipi_irq == '0 && core_stall == '0 && core_ext_irq == '0));

endmodule

bind mcid_top mcid_checker #(
    .NUM_CORES(NUM_CORES), .NUM_EXT(NUM_EXT), .NUM_CAUSES(NUM_CAUSES)
) u_checker (
    .clk          (clk),
    .rst          (rst),
    .bus_addr     (bus_addr),
    .bus_wr       (bus_wr),
    .bus_rd       (bus_rd),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata),
    .core_ext_irq (core_ext_irq),
    .ipi_irq      (ipi_irq),
    .core_stall   (core_stall)
);

// File: tb/test_mcid_top.sv
module test_mcid_top;

    localparam int NC = 4;
    localparam int NE = 8;
    localparam int NK = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NE-1:0] irq_in = '0;
    logic [9:0]    bus_addr = '0;
    logic          bus_wr = 1'b0;
    logic          bus_rd = 1'b0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NC*NE-1:0] core_ext_irq;
    logic [NC-1:0] ipi_irq;
    logic [NC-1:0] core_stall;

    int n_cmp = 0;
    int n_bad = 0;

    // bench model
    logic [NC-1:0] rt_m [NE];
    logic [NE-1:0] en_m = '0;
    logic [NE-1:0] asg_m = '0;
    logic [NK-1:0] cz_m [NC];

    always #5 clk = ~clk;

    mcid_top i_mcid_top (
        .clk(clk), .rst(rst), .irq_in(irq_in), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .core_ext_irq(core_ext_irq),
        .ipi_irq(ipi_irq), .core_stall(core_stall)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [9:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [9:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    function automatic logic [31:0] exp_ext();
        logic [31:0] v = '0;
        for (int p = 0; p < NC; p++)
            for (int n = 0; n < NE; n++)
                v[p*NE+n] = (irq_in[n] | asg_m[n]) & en_m[n] & rt_m[n][p];
        return v;
    endfunction

    function automatic logic [NC-1:0] exp_ipi();
        logic [NC-1:0] v;
        for (int p = 0; p < NC; p++) v[p] = |cz_m[p];
        return v;
    endfunction

    task automatic chk_ipi(input string req);
        logic [31:0] d;
        #1 chk(req, 32'(ipi_irq), 32'(exp_ipi()));
        for (int p = 0; p < NC; p++) begin
            rd(10'h100 + 10'(p), d);
            chk(req, d, 32'(cz_m[p]));
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : main
        logic [31:0] d;
        logic [NK-1:0] post_mask [NK];
        post_mask[0] = 4'b0001; post_mask[1] = 4'b0011;
        post_mask[2] = 4'b0110; post_mask[3] = 4'b1100;
        for (int n = 0; n < NE; n++) rt_m[n] = 4'b0001;
        for (int p = 0; p < NC; p++) cz_m[p] = '0;

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R12 reset state
        #1 chk("R12 ext", core_ext_irq, 32'h0);
        chk("R12 ipi", 32'(ipi_irq), 32'h0);
        chk("R12 stall", 32'(core_stall), 32'h0);
        chk("R12 idle rdata", bus_rdata, 32'h0);
        for (int n = 0; n < NE; n++) begin
            rd(10'(n), d);
            chk("R12 route reset", d, 32'h1);
        end
        rd(10'h180, d); chk("R12 enable reset", d, 32'h0);
        rd(10'h188, d); chk("R12 assert reset", d, 32'h0);
        rd(10'h190, d); chk("R12 partition reset", d, 32'h0);
        rd(10'h220, d); chk("R12 coherency reset", d, 32'h0);
        rd(10'h3FC, d); chk("R12 unmapped", d, 32'h0);
        rd(10'h104, d); chk("R12 unmapped cause", d, 32'h0);
        rd(10'h150, d); chk("R12 unmapped post", d, 32'h0);
        chk_ipi("R12 causes");

        // R9 config word, write ignored
        rd(10'h1A0, d); chk("R9 config", d, {10'h2A5, 4'd3, 18'h1C0DE});
        wr(10'h1A0, 32'hFFFF_FFFF);
        rd(10'h1A0, d); chk("R9 config after write", d, {10'h2A5, 4'd3, 18'h1C0DE});

        // R3 enable set
        wr(10'h184, 32'h0000_00FF); en_m = 8'hFF;
        rd(10'h184, d); chk("R3 enable set", d, 32'hFF);

        // R1 sweep over every line and every core
        for (int n = 0; n < NE; n++) begin
            for (int p = 0; p < NC; p++) begin
                wr(10'(n), 32'h1 << p); rt_m[n] = 4'(1 << p);
                rd(10'(n), d); chk("R1 route readback", d, 32'(rt_m[n]));
                irq_in = 8'hFF;        #1 chk("R1 all high", core_ext_irq, exp_ext());
                irq_in = 8'h00;        #1 chk("R1 all low", core_ext_irq, exp_ext());
                irq_in = 8'(1 << n);   #1 chk("R1 single", core_ext_irq, exp_ext());
                irq_in = ~8'(1 << n);  #1 chk("R1 others", core_ext_irq, exp_ext());
            end
        end
        wr(10'h002, 32'h0000_000B); rt_m[2] = 4'b1011;
        irq_in = 8'h04; #1 chk("R1 multi-core route", core_ext_irq, exp_ext());

        // R2 partial clear leaves other bits
        wr(10'h180, 32'h0000_000F); en_m = en_m & ~8'h0F;
        rd(10'h180, d); chk("R2 enable clear", d, 32'hF0);
        irq_in = 8'hFF; #1 chk("R2 gated outputs", core_ext_irq, exp_ext());
        wr(10'h184, 32'h0000_0004); en_m = en_m | 8'h04;
        rd(10'h180, d); chk("R3 set one bit", d, 32'hF4);

        // R7 global assert
        irq_in = 8'h00;
        wr(10'h18C, 32'h0000_0085); asg_m = 8'h85;
        rd(10'h188, d); chk("R7 assert set", d, 32'h85);
        #1 chk("R7 assert drives lines", core_ext_irq, exp_ext());
        wr(10'h188, 32'h0000_0004); asg_m = 8'h81;
        rd(10'h18C, d); chk("R7 assert clear", d, 32'h81);
        #1 chk("R7 after clear", core_ext_irq, exp_ext());

        // R4, R5 posting causes with distinct masks
        for (int c = 0; c < NK; c++) begin
            wr(10'h140 + 10'(c), 32'(post_mask[c]));
            for (int p = 0; p < NC; p++) if (post_mask[c][p]) cz_m[p][c] = 1'b1;
            chk_ipi("R4 R5 post");
        end

        // R6 acknowledge
        wr(10'h101, 32'h0000_0001); cz_m[1][0] = 1'b0;
        chk_ipi("R6 partial ack");
        for (int p = 0; p < NC; p++) begin
            wr(10'h100 + 10'(p), 32'hFFFF_FFFF); cz_m[p] = '0;
        end
        chk_ipi("R6 full ack");

        // R8 partition
        wr(10'h190, 32'h0000_01FF);
        rd(10'h190, d); chk("R8 partition", d, 32'hFF);

        // R10 stall
        wr(10'h200, 32'hFFFF_FFFA);
        #1 chk("R10 stall out", 32'(core_stall), 32'hA);
        rd(10'h200, d); chk("R10 stall read", d, 32'hA);

        // R11 coherency flag
        wr(10'h220, 32'h0000_0003);
        rd(10'h220, d); chk("R11 coherency set", d, 32'h1);
        wr(10'h220, 32'h0000_0000);
        rd(10'h220, d); chk("R11 coherency clear", d, 32'h0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule